// File: doc/BRIEF.md
# Reset-Time Debug Mode Entry Controller

This block owns the release of an internally driven reset and decides, from one debug-request pin, how the processor starts. Once the reset request is withdrawn, the block keeps its reset output held for a programmable number of cycles. At a fixed point three cycles before it lets go, it takes a sample of the pin after a two-flop synchronizer. That sample decides whether debug mode is enabled until the next reset.

After release, the block watches the same pin for a short window. If debug mode is enabled and the pin is still asserted when the window closes, it emits a one-cycle request for a breakpoint entry straight into debug mode and latches the development-port cause bit (bit 31 of the cause register). Otherwise it emits a one-cycle normal-boot pulse, which starts a reset-vector fetch.

The block also holds two 32-bit development-support registers, a cause register and an enable register. It grants access to them according to the enable state and the CPU mode. The bits that are set in both registers drive a freeze output.

Top module: `rst_dbg_gate`

## Requirements
- R1: `rst_done` is 0 while `rst_req` is 1. Let edge 1 be the first rising clock edge at which `rst_req` is sampled 0. `rst_done` becomes 1 at edge HOLD and stays 1 until the next `rst_req`.
- R2: `dbg_en` takes the synchronized pin value at edge HOLD-3, three edges before release. With the two-flop synchronizer, this is the pin level at edge HOLD-5. A pin pulse one edge earlier or later leaves `dbg_en` at 0.
- R3: `dbg_en` is cleared while `rst_req` is 1. After release it keeps its sampled value regardless of pin activity.
- R4: At edge HOLD+WIN, the block checks `dbg_en` and the synchronized pin, which is the pin level at edge HOLD+WIN-2. If both are 1, `dbg_entry` is high for exactly the one cycle following that edge.
- R5: If the R4 condition does not hold at edge HOLD+WIN, `boot_go` pulses for that one cycle instead. Exactly one of the two pulses occurs per reset, and neither occurs at any other time.
- R6: A debug entry sets cause bit 31, shown on `cause31`. The bit stays set until a granted write to the cause register (`acc_sel`=0) clears it.
- R7: With `dbg_en`=0, an access is granted only when `priv`=0 (supervisor). `in_dbg` has no effect on the grant.
- R8: With `dbg_en`=1, an access is granted only when `in_dbg`=1. `priv` has no effect on the grant.
- R9: An access that is not granted drives `acc_err`=1 and `acc_rdata`=0, and its write changes no register. A granted read returns the selected register: `acc_sel`=0 selects the cause register and `acc_sel`=1 selects the enable register.
- R10: `freeze` is 1 exactly when some bit is set in both the cause register and the enable register, in either enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_req | input | 1 | Reset request, active high, synchronous |
| dbg_pin | input | 1 | Debug-request pin, asynchronous |
| priv | input | 1 | Privilege flag, 0 = supervisor |
| in_dbg | input | 1 | CPU currently in debug mode |
| acc_req | input | 1 | Register access strobe |
| acc_we | input | 1 | Access is a write |
| acc_sel | input | 1 | 0 = cause register, 1 = enable register |
| acc_wdata | input | 32 | Write data |
| rst_done | output | 1 | Reset released |
| dbg_en | output | 1 | Debug mode enabled |
| dbg_entry | output | 1 | One-cycle debug entry request |
| boot_go | output | 1 | One-cycle normal boot request |
| cause31 | output | 1 | Development-port cause bit |
| acc_grant | output | 1 | Access granted |
| acc_err | output | 1 | Access refused |
| acc_rdata | output | 32 | Read data, 0 when refused |
| freeze | output | 1 | Freeze request |

## Verification
The bench builds the block with HOLD=8 and WIN=7. With these values, the enable sample falls on pin edge 3 and the entry decision on pin edge 13 after the request is withdrawn. This keeps both boundaries within a few cycles, so one-cycle pin pulses can land on, before and after the sample point. Pin negation can likewise be placed exactly at the last edge of the window or one edge before it. Each reset takes under twenty cycles, which leaves room for enabled and disabled runs followed by access-policy and freeze checks in both modes.

// File: rtl/rst_dbg_gate.sv
module rst_dbg_gate #(
  parameter int HOLD = 8,
  parameter int WIN  = 7,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_req,
  input  logic          dbg_pin,
  input  logic          priv,
  input  logic          in_dbg,
  input  logic          acc_req,
  input  logic          acc_we,
  input  logic          acc_sel,
  input  logic [DW-1:0] acc_wdata,
  output logic          rst_done,
  output logic          dbg_en,
  output logic          dbg_entry,
  output logic          boot_go,
  output logic          cause31,
  output logic          acc_grant,
  output logic          acc_err,
  output logic [DW-1:0] acc_rdata,
  output logic          freeze
);
  localparam int HW = $clog2(HOLD + 1);
  localparam int WW = $clog2(WIN + 1);
  localparam logic [HW-1:0] SAMPLE_AT  = HW'(HOLD - 4);
  localparam logic [HW-1:0] RELEASE_AT = HW'(HOLD - 1);
  localparam logic [WW-1:0] DECIDE_AT  = WW'(WIN - 1);

  logic          s1, s2;
  logic [HW-1:0] hcnt;
  logic [WW-1:0] wcnt;
  logic          decided;
  logic [DW-1:0] cause_q, enab_q;
  logic          decide, take;

  always_ff @(posedge clk) begin
    s1 <= dbg_pin;
    s2 <= s1;
  end

  always_ff @(posedge clk) begin
    if (rst_req) begin
      hcnt     <= '0;
      rst_done <= 1'b0;
      dbg_en   <= 1'b0;
    end else if (!rst_done) begin
      hcnt <= hcnt + 1'b1;
      if (hcnt == SAMPLE_AT)  dbg_en   <= s2;
      if (hcnt == RELEASE_AT) rst_done <= 1'b1;
    end
  end

  assign decide = rst_done && !decided && (wcnt == DECIDE_AT);
  assign take   = decide && dbg_en && s2;

  always_ff @(posedge clk) begin
    if (rst_req) begin
      wcnt      <= '0;
      decided   <= 1'b0;
      dbg_entry <= 1'b0;
      boot_go   <= 1'b0;
    end else begin
      dbg_entry <= take;
      boot_go   <= decide && !take;
      if (rst_done && !decided) begin
        wcnt <= wcnt + 1'b1;
        if (decide) decided <= 1'b1;
      end
    end
  end

  assign acc_grant = acc_req && (dbg_en ? in_dbg : !priv);
  assign acc_err   = acc_req && !acc_grant;
  assign acc_rdata = acc_grant ? (acc_sel ? enab_q : cause_q) : '0;

  always_ff @(posedge clk) begin
    if (rst_req) begin
      cause_q <= '0;
      enab_q  <= '0;
    end else begin
      if (acc_grant && acc_we && !acc_sel) cause_q <= acc_wdata;
      if (acc_grant && acc_we &&  acc_sel) enab_q  <= acc_wdata;
      if (take) cause_q[DW-1] <= 1'b1;
    end
  end

  assign cause31 = cause_q[DW-1];
  assign freeze  = |(cause_q & enab_q);
endmodule

module rst_dbg_gate_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_req,
  input logic          priv,
  input logic          in_dbg,
  input logic          rst_done,
  input logic          dbg_en,
  input logic          dbg_entry,
  input logic          boot_go,
  input logic          cause31,
  input logic          acc_grant,
  input logic          acc_err,
  input logic [DW-1:0] acc_rdata
);
  a_r1_held_on_fall: assert property (@(posedge clk) disable iff (rst_req)
    $fell(rst_req) |-> !rst_done);
  a_r3_en_stable: assert property (@(posedge clk) disable iff (rst_req)
    (rst_done && $past(rst_done)) |-> $stable(dbg_en));
  a_r4_entry_needs_en: assert property (@(posedge clk) disable iff (rst_req)
    dbg_entry |-> (dbg_en && rst_done));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst_req)
    !(dbg_entry && boot_go));
  a_r5_boot_single: assert property (@(posedge clk) disable iff (rst_req)
    boot_go |=> !boot_go);
  a_r4_entry_single: assert property (@(posedge clk) disable iff (rst_req)
    dbg_entry |=> !dbg_entry);
  a_r6_cause_set: assert property (@(posedge clk) disable iff (rst_req)
    dbg_entry |-> cause31);
  a_r7_disabled_priv: assert property (@(posedge clk) disable iff (rst_req)
    (acc_grant && !dbg_en) |-> !priv);
  a_r8_enabled_dbg: assert property (@(posedge clk) disable iff (rst_req)
    (acc_grant && dbg_en) |-> in_dbg);
  a_r9_refused_zero: assert property (@(posedge clk) disable iff (rst_req)
    acc_err |-> (acc_rdata == '0 && !acc_grant));
endmodule

bind rst_dbg_gate rst_dbg_gate_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_rst_dbg_gate.sv
module tb_rst_dbg_gate;
  localparam int PER  = 10;
  localparam int HOLD = 8;
  localparam int WIN  = 7;

  logic clk = 0, rst_req = 1, dbg_pin = 0, priv = 0, in_dbg = 0;
  logic acc_req = 0, acc_we = 0, acc_sel = 0;
  logic [31:0] acc_wdata = 0;
  logic rst_done, dbg_en, dbg_entry, boot_go, cause31, acc_grant, acc_err, freeze;
  logic [31:0] acc_rdata;

  int checks = 0, errors = 0;
  longint expq[$];
  string  nameq[$];

  always #(PER/2) clk = ~clk;

  rst_dbg_gate #(.HOLD(HOLD), .WIN(WIN)) dut (.*);

  function automatic void push(string n, longint e);
    nameq.push_back(n);
    expq.push_back(e);
  endfunction

  function automatic void pop_cmp(longint act);
    string n;
    longint e;
    n = nameq.pop_front();
    e = expq.pop_front();
    checks++;
    if (act != e) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", n, act, e);
    end
  endfunction

  task automatic boot(input int from, input int to);
    bit en_exp, ent_exp;
    @(negedge clk);
    rst_req = 1;
    dbg_pin = 0;
    repeat (3) @(negedge clk);
    push("R1 held in reset", 0); pop_cmp(rst_done);
    push("R3 cleared in reset", 0); pop_cmp(dbg_en);
    rst_req = 0;
    dbg_pin = (1 >= from && 1 <= to);
    en_exp  = ((HOLD-5) >= from && (HOLD-5) <= to);
    ent_exp = en_exp && ((HOLD+WIN-2) >= from && (HOLD+WIN-2) <= to);
    for (int j = 1; j <= HOLD + WIN + 1; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (j == HOLD-1) begin push("R1 before release", 0); pop_cmp(rst_done); end
      if (j == HOLD)   begin push("R1 at release", 1);     pop_cmp(rst_done); end
      if (j == HOLD) begin push("R2 enable sample", en_exp); pop_cmp(dbg_en); end
      if (j == HOLD+WIN-1 || j == HOLD+WIN+1) begin
        push("R5 no early/late pulse", 0); pop_cmp({dbg_entry, boot_go});
      end
      if (j == HOLD+WIN) begin
        push("R4 entry pulse", ent_exp);  pop_cmp(dbg_entry);
        push("R5 boot pulse", !ent_exp);  pop_cmp(boot_go);
      end
      dbg_pin = ((j+1) >= from && (j+1) <= to);
    end
    dbg_pin = 0;
  endtask

  task automatic acc(input bit we, input bit sel, input logic [31:0] wd,
                     input bit pv, input bit idb,
                     input bit g_exp, input logic [31:0] rd_exp, input string n);
    @(negedge clk);
    acc_req = 1; acc_we = we; acc_sel = sel; acc_wdata = wd; priv = pv; in_dbg = idb;
    #1;
    push({n, " grant"}, g_exp);  pop_cmp(acc_grant);
    push({n, " err"}, !g_exp);   pop_cmp(acc_err);
    push({n, " rdata"}, rd_exp); pop_cmp(acc_rdata);
    @(negedge clk);
    acc_req = 0; acc_we = 0;
  endtask

  initial begin
    #(PER*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // enabled, pin held: entry
    boot(1, 40);
    push("R6 cause set", 1); pop_cmp(cause31);
    repeat (4) begin
      @(negedge clk); dbg_pin = ~dbg_pin;
    end
    push("R3 enable held", 1); pop_cmp(dbg_en);
    push("R6 cause held", 1);  pop_cmp(cause31);
    acc(0, 0, 0, 0, 0, 0, 32'h0, "R8 supervisor outside debug");
    acc(0, 0, 0, 1, 1, 1, 32'h8000_0000, "R8 problem in debug");
    acc(1, 1, 32'h8000_0000, 0, 0, 0, 32'h0, "R9 refused write");
    acc(0, 1, 0, 1, 1, 1, 32'h0, "R9 enable unchanged");
    push("R10 freeze off", 0); pop_cmp(freeze);
    acc(1, 1, 32'h8000_0000, 1, 1, 1, 32'h0, "R8 granted write");
    push("R10 freeze on", 1); pop_cmp(freeze);
    acc(1, 0, 32'h0, 0, 1, 1, 32'h8000_0000, "R6 clear write");
    push("R6 cause cleared", 0); pop_cmp(cause31);
    push("R10 freeze off again", 0); pop_cmp(freeze);

    // enable boundary: pin only at sample edge
    boot(HOLD-5, HOLD-5);
    // pulse one edge early / late
    boot(HOLD-6, HOLD-6);
    boot(HOLD-4, 40);
    push("R4 no entry when disabled", 0); pop_cmp(cause31);
    acc(0, 0, 0, 0, 0, 1, 32'h0, "R7 supervisor");
    acc(0, 0, 0, 1, 1, 0, 32'h0, "R7 problem in debug");
    acc(1, 0, 32'h0000_0001, 0, 0, 1, 32'h0, "R7 write cause");
    acc(1, 1, 32'h0000_0001, 0, 0, 1, 32'h0, "R7 write enable");
    push("R10 freeze disabled mode", 1); pop_cmp(freeze);

    // window boundary
    boot(1, HOLD+WIN-2);
    boot(1, HOLD+WIN-3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule